// File: doc/BRIEF.md
# Page Program Collection Buffer

This block sits between a serial flash front end and a behavioural flash array. It handles the data phase of a page program command. When a command opens, the block latches the page and the starting byte offset. Each data byte that the front end reports is stored into a page-sized buffer at the current offset. The offset then advances and wraps inside the page. A per-offset flag records which locations have received data. If more bytes arrive than the page holds, the later bytes overwrite the earlier ones, so the buffer always keeps the most recent page's worth.

When chip enable rises, the block decides whether to commit. It needs at least one complete byte, no byte cut short by the rise, the write-enable latch set and the target not protected. If all of these hold, it raises busy for a fixed number of clock cycles set by a parameter. During the first page-length cycles of that window it steps through every offset of the page in ascending order. For each flagged offset it emits one array write strobe carrying the full address and the buffered byte. Offsets that received no data produce no strobe. The array is expected to AND the strobed byte into its stored value, so programming can only clear bits. When busy drops, the block pulses a request to clear the write-enable latch.

Top module: `page_prog_buf`

## Requirements
- R1: During and right after reset, `busy`, `arr_we` and `wel_clr` are 0.
- R2: The first data byte goes to the page offset given by the low 8 bits of `start_addr`. Each later byte goes to the next offset up. All strobes use the page number in `start_addr[ADDR_W-1:8]`.
- R3: A byte that would fall past offset 255 wraps to offset 0 of the same page. No strobe ever addresses another page.
- R4: When more than 256 bytes are sent, each offset commits the last byte sent to it, so exactly the final 256 bytes are kept.
- R5: A page offset that received no byte in the command gets no write strobe, so its array contents do not change.
- R6: A command closed while `wel` is 0 or `prot` is 1 is ignored: no busy, no strobe, no `wel_clr`.
- R7: A command is discarded with no busy, no strobe and no `wel_clr` in either of two cases: chip enable rises before any complete byte, or `byte_partial` is 1 at the rise.
- R8: For a valid command, `busy` is 1 from the cycle after the `cs_rise` cycle for exactly `PROG_CYCLES` cycles. All write strobes occur inside that window.
- R9: `wel_clr` is a single-cycle pulse. It appears in the first cycle with `busy` at 0 after a program, and only then.
- R10: While `busy` is 1, new command starts, data bytes and chip-enable rises are ignored. The running program keeps its length and contents.
- R11: A data byte reported in the same cycle as `cs_rise` is complete. It is stored and counts toward the one-byte minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | One-cycle pulse: a page program command with its address has been received |
| start_addr | input | ADDR_W | Page number in the upper bits, first byte offset in the low 8 bits |
| byte_valid | input | 1 | One-cycle strobe: a complete data byte is on `byte_data` |
| byte_data | input | 8 | Data byte |
| cs_rise | input | 1 | One-cycle pulse: chip enable has returned high |
| byte_partial | input | 1 | With `cs_rise`: the front end held an incomplete byte |
| wel | input | 1 | Write-enable latch state |
| prot | input | 1 | Target page lies in a protected area |
| busy | output | 1 | Program in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array byte address for the strobe |
| arr_wdata | output | 8 | Byte to AND into the array location |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |

## Verification
Two functions can land on the same clock edge, and both are provoked directly. First, the last data byte can coincide with the chip-enable rise. A directed case sends a single byte in the `cs_rise` cycle. The program must then start and must strobe exactly that byte at the start offset. Second, the busy window can coincide with a fresh command. A second full command is issued mid-program: start, bytes and rise, all with `wel` set. The busy length must stay at `PROG_CYCLES`, no second busy window may follow, and the array image must show only the first command's bytes.

// File: rtl/pp_pkg.sv
// Package: shared widths for the page program buffer.
// Assumes byte-wide array data and power-of-two page sizes.
package pp_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pp_collect.sv
// Module: pp_collect
// Captures the data bytes of one page program command into a page buffer.
// Keeps a written flag per offset, advances the offset with in-page wrap,
// and raises commit_req when chip enable closes a well-formed command.
// Assumes PAGE_BYTES is a power of two and that hold blocks new commands.
module pp_collect
    import pp_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int PAGE_BYTES = 256
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_start,
    input  logic [ADDR_W-1:0]           start_addr,
    input  logic                        byte_valid,
    input  byte_t                       byte_data,
    input  logic                        cs_rise,
    input  logic                        byte_partial,
    input  logic                        hold,
    input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx,
    output byte_t                       rd_data,
    output logic                        rd_valid,
    output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page,
    output logic                        commit_req
);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic                  active_q;
    logic                  got_q;
    logic [OFF_W-1:0]      ptr_q;
    logic [PAGE_W-1:0]     page_q;
    byte_t                 mem_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;

    logic new_cmd;
    logic take_byte;

    assign new_cmd   = cmd_start && !hold;
    assign take_byte = active_q && byte_valid && !new_cmd;

    // Command framing: open on a start, track the offset, close on CE rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            got_q    <= 1'b0;
            ptr_q    <= '0;
            page_q   <= '0;
        end else if (new_cmd) begin
            active_q <= 1'b1;
            got_q    <= 1'b0;
            ptr_q    <= start_addr[OFF_W-1:0];
            page_q   <= start_addr[ADDR_W-1:OFF_W];
        end else begin
            if (take_byte) begin
                ptr_q <= ptr_q + OFF_W'(1);
                got_q <= 1'b1;
            end
            if (cs_rise) begin
                active_q <= 1'b0;
            end
        end
    end

    // Written flags: cleared per command, set per received byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (new_cmd) begin
            vld_q <= '0;
        end else if (take_byte) begin
            vld_q[ptr_q] <= 1'b1;
        end
    end

    // Data storage: later bytes to the same offset overwrite earlier ones.
    always_ff @(posedge clk) begin
        if (take_byte) begin
            mem_q[ptr_q] <= byte_data;
        end
    end

    assign commit_req = active_q && cs_rise && !new_cmd && !byte_partial
                        && (got_q || byte_valid);
    assign rd_data    = mem_q[rd_idx];
    assign rd_valid   = vld_q[rd_idx];
    assign page       = page_q;

    // R10
    hold_no_collect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !active_q);
endmodule

// File: rtl/pp_timer.sv
// Module: pp_timer
// Self-timed program window. It holds busy for PROG_CYCLES cycles after go,
// exposes a walk index over the first PAGE_BYTES cycles, and pulses done
// once as busy falls. Assumes PROG_CYCLES >= PAGE_BYTES.
module pp_timer #(
    parameter int PAGE_BYTES  = 256,
    parameter int PROG_CYCLES = 300
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          go,
    output logic                          busy,
    output logic                          walk_on,
    output logic [$clog2(PAGE_BYTES)-1:0] walk_idx,
    output logic                          done
);
    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_q;

    // Window control: start on go when idle, end after the set length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (go) begin
                    busy_q <= 1'b1;
                    cnt_q  <= '0;
                end
            end else if (cnt_q == CNT_W'(PROG_CYCLES - 1)) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign busy     = busy_q;
    assign done     = done_q;
    assign walk_on  = busy_q && (cnt_q < CNT_W'(PAGE_BYTES));
    assign walk_idx = cnt_q[OFF_W-1:0];

    // Independent run-length counter used only by the window check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (busy_q) begin
            len_q <= len_q + CNT_W'(1);
        end else begin
            len_q <= '0;
        end
    end

    // R8
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> (len_q == CNT_W'(PROG_CYCLES)));
    // R9
    done_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $fell(busy_q));
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/page_prog_buf.sv
// Module: page_prog_buf (top)
// Collects one page program command, qualifies it with write enable and
// protection at CE rise, then replays the flagged buffer bytes as array
// write strobes within a timed busy window and requests a latch clear.
// Assumes the array ANDs each strobed byte into its stored value.
module page_prog_buf
    import pp_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int PAGE_BYTES  = 256,
    parameter int PROG_CYCLES = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              cs_rise,
    input  logic              byte_partial,
    input  logic              wel,
    input  logic              prot,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata,
    output logic              wel_clr
);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFF_W;

    logic              commit_req;
    logic              go;
    logic              walk_on;
    logic [OFF_W-1:0]  walk_idx;
    byte_t             rd_data;
    logic              rd_valid;
    logic [PAGE_W-1:0] page;

    pp_collect #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_collect (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start),
        .start_addr(start_addr), .byte_valid(byte_valid),
        .byte_data(byte_data), .cs_rise(cs_rise),
        .byte_partial(byte_partial), .hold(busy), .rd_idx(walk_idx),
        .rd_data(rd_data), .rd_valid(rd_valid), .page(page),
        .commit_req(commit_req)
    );

    assign go = commit_req && wel && !prot;

    pp_timer #(.PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .go(go), .busy(busy),
        .walk_on(walk_on), .walk_idx(walk_idx), .done(wel_clr)
    );

    assign arr_we    = walk_on && rd_valid;
    assign arr_addr  = {page, walk_idx};
    assign arr_wdata = rd_data;

    // R6
    gated_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel && !prot && cs_rise));
    // R8
    strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);
endmodule

// File: tb/tb_page_prog_buf.sv
module tb_page_prog_buf;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 20;
    localparam int PROG       = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 1'b0, byte_valid = 1'b0, cs_rise = 1'b0;
    logic byte_partial = 1'b0, wel = 1'b0, prot = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [7:0] byte_data = '0;
    logic busy, arr_we, wel_clr;
    logic [ADDR_W-1:0] arr_addr;
    logic [7:0] arr_wdata;

    int errors = 0, checks = 0;
    logic [7:0] mem [1024];
    logic [7:0] exp_mem [1024];

    always #(CLK_PERIOD/2) clk = ~clk;

    page_prog_buf #(.ADDR_W(ADDR_W), .PAGE_BYTES(256), .PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .start_addr(start_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .cs_rise(cs_rise),
        .byte_partial(byte_partial), .wel(wel), .prot(prot), .busy(busy),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .wel_clr(wel_clr)
    );

    typedef struct packed {
        logic [1:0] page; logic [7:0] off; logic [9:0] n; logic [7:0] seed;
        logic wel; logic prot; logic part;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{2'd0, 8'h00, 10'd256, 8'h5A, 1'b1, 1'b0, 1'b0},  // R2 full page
        '{2'd1, 8'hF0, 10'd32,  8'h3C, 1'b1, 1'b0, 1'b0},  // R3 wrap
        '{2'd2, 8'h10, 10'd300, 8'hC3, 1'b1, 1'b0, 1'b0},  // R4 overflow
        '{2'd3, 8'h80, 10'd1,   8'h77, 1'b1, 1'b0, 1'b0},  // R5 single byte
        '{2'd0, 8'h00, 10'd16,  8'hA5, 1'b1, 1'b0, 1'b0},  // R2 reprogram, AND
        '{2'd1, 8'h00, 10'd8,   8'h00, 1'b0, 1'b0, 1'b0},  // R6 no write enable
        '{2'd1, 8'h00, 10'd8,   8'h00, 1'b1, 1'b1, 1'b0},  // R6 protected
        '{2'd2, 8'h00, 10'd0,   8'h00, 1'b1, 1'b0, 1'b0},  // R7 no byte
        '{2'd2, 8'h00, 10'd4,   8'h00, 1'b1, 1'b0, 1'b1},  // R7 partial byte
        '{2'd3, 8'hFF, 10'd2,   8'h19, 1'b1, 1'b0, 1'b0}   // R3 wrap at last offset
    };

    function automatic string req_of(input int k);
        case (k)
            1, 9:    return "R3";
            2:       return "R4";
            3:       return "R5";
            5, 6:    return "R6";
            7, 8:    return "R7";
            default: return "R2";
        endcase
    endfunction

    function automatic logic [7:0] dgen(input logic [7:0] s, input int i);
        return s ^ 8'(i * 29) ^ 8'(i >> 8);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Reference: bytes in order, offset wraps, last write per offset wins.
    task automatic model(input logic [1:0] pg, input logic [7:0] off,
                         input int n, input logic [7:0] seed);
        logic [7:0] b [256];
        bit w [256];
        for (int o = 0; o < 256; o++) w[o] = 0;
        for (int i = 0; i < n; i++) begin
            b[(off + i) % 256] = dgen(seed, i);
            w[(off + i) % 256] = 1;
        end
        for (int o = 0; o < 256; o++)
            if (w[o]) exp_mem[pg * 256 + o] = exp_mem[pg * 256 + o] & b[o];
    endtask

    // Observe the window after a CE rise; optionally inject a command mid-busy.
    task automatic monitor(input bit expc, input logic [1:0] pg, input string req,
                           input bit inject);
        int bn = 0, cn = 0, outside = 0, clr_ok = 0;
        bit prev_busy = 0;
        bit first_busy = busy;
        for (int j = 0; j < PROG + 20; j++) begin
            if (busy) bn++;
            if (wel_clr) begin
                cn++;
                if (prev_busy && !busy) clr_ok++;
            end
            if (arr_we) begin
                if (arr_addr[ADDR_W-1:8] != 12'(pg)) outside++;
                mem[arr_addr[9:0]] = mem[arr_addr[9:0]] & arr_wdata;
            end
            prev_busy = busy;
            if (inject) begin
                cmd_start  = (j == 5);
                start_addr = 20'h00000;
                byte_valid = (j >= 6 && j <= 8);
                byte_data  = 8'h00;
                cs_rise    = (j == 9);
            end
            @(negedge clk);
        end
        check(first_busy == expc, "R8", {req, " busy in cycle after CE rise"}, first_busy, expc);
        check(bn == (expc ? PROG : 0), "R8", {req, " busy length"}, bn, expc ? PROG : 0);
        check(cn == int'(expc) && clr_ok == int'(expc), "R9", {req, " wel_clr pulse"}, cn, int'(expc));
        check(outside == 0, "R3", {req, " strobes outside page"}, outside, 0);
    endtask

    task automatic compare_mem(input string req, input string what);
        int bad = 0, first = -1;
        for (int a = 0; a < 1024; a++)
            if (mem[a] !== exp_mem[a]) begin
                bad++;
                if (first < 0) first = a;
            end
        check(bad == 0, req, {what, " array image (actual=mismatches)"}, bad, 0);
        if (bad != 0)
            $display("  first mismatch addr %0d actual=%0h expected=%0h", first, mem[first], exp_mem[first]);
    endtask

    task automatic send_cmd(input logic [1:0] pg, input logic [7:0] off, input int n,
                            input logic [7:0] seed, input bit part, input bit last_with_rise);
        cmd_start = 1'b1; start_addr = 20'({pg, off});
        @(negedge clk);
        cmd_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_valid = 1'b1; byte_data = dgen(seed, i);
            if (last_with_rise && i == n - 1) cs_rise = 1'b1;
            @(negedge clk);
            byte_valid = 1'b0;
        end
        if (!(last_with_rise && n > 0)) begin
            byte_partial = part; cs_rise = 1'b1;
            @(negedge clk);
        end
        cs_rise = 1'b0; byte_partial = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int a = 0; a < 1024; a++) begin mem[a] = 8'hFF; exp_mem[a] = 8'hFF; end
        repeat (3) @(negedge clk);
        // R1 in reset
        check(busy == 0 && arr_we == 0 && wel_clr == 0, "R1", "outputs in reset",
              {busy, arr_we, wel_clr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 after reset
        check(busy == 0 && arr_we == 0 && wel_clr == 0, "R1", "outputs after reset",
              {busy, arr_we, wel_clr}, 0);

        for (int k = 0; k < 10; k++) begin
            bit expc;
            vec_t v = VECS[k];
            expc = v.wel && !v.prot && !v.part && (v.n != 0);
            wel = v.wel; prot = v.prot;
            send_cmd(v.page, v.off, int'(v.n), v.seed, v.part, 1'b0);
            if (expc) model(v.page, v.off, int'(v.n), v.seed);
            monitor(expc, v.page, $sformatf("%s vec%0d", req_of(k), k), 1'b0);
            compare_mem(req_of(k), $sformatf("vec%0d", k));
        end

        // R11: single byte arrives together with the CE rise
        wel = 1'b1; prot = 1'b0;
        send_cmd(2'd3, 8'h40, 1, 8'h0F, 1'b0, 1'b1);
        model(2'd3, 8'h40, 1, 8'h0F);
        monitor(1'b1, 2'd3, "R11 byte with rise", 1'b0);
        compare_mem("R11", "byte with rise");

        // R10: full command issued during busy is ignored
        send_cmd(2'd2, 8'h20, 4, 8'h81, 1'b0, 1'b0);
        model(2'd2, 8'h20, 4, 8'h81);
        monitor(1'b1, 2'd2, "R10 command in busy", 1'b1);
        cmd_start = 1'b0; byte_valid = 1'b0; cs_rise = 1'b0;
        compare_mem("R10", "command in busy");
        repeat (5) @(negedge clk);
        check(busy == 0, "R10", "no program after ignored command", busy, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule